// File: doc/BRIEF.md
# BCD Reloadable Watchdog Countdown Timer

This block is a watchdog and interval timer. Software sets its period through two byte-wide registers that together hold four BCD digits, a time from 00.01 to 99.99 seconds. A hidden counter loads that value and steps down by one on every 100 Hz tick enable. When the count runs out, the block raises a sticky flag and an active-low interrupt, emits a one-cycle expiry strobe, reloads itself and starts the next period.

Any bus access to either period register restarts the countdown and clears the flag and the interrupt. Reads count as well as writes. The processor services the watchdog by touching a register at regular intervals, and it misses nothing if it also reads the period back. Reads always return the programmed digits, never the live count. A period of all zero digits stops the timer entirely.

Top module: `bcd_wdog`

## Requirements
- R1: After reset both period registers are zero, `wd_flag` is 0, `wd_irq_n` is 1, `expire_pulse` is 0 and `reg_rdata` is 0.
- R2: Register address 0 holds hundredths in bits 3:0 and tenths in bits 7:4. Address 1 holds seconds units in bits 3:0 and tens of seconds in bits 7:4. The period in ticks is the decimal value of these four digits, with BCD borrow across every digit boundary.
- R3: With a nonzero period P, `expire_pulse` and `wd_flag` rise at the clock edge that samples the P-th `tick_100hz` after the last access. They do not rise before that edge.
- R4: `wd_irq_n` falls at the same edge as `wd_flag` rises. Both stay asserted through later automatic reloads until the next access.
- R5: Left unserviced, the counter reloads itself and `expire_pulse` repeats every P ticks.
- R6: A read or a write of either register (`reg_sel` high for one cycle) reloads the count and clears `wd_flag` and `wd_irq_n` at that edge. An access wins over a tick that arrives in the same cycle.
- R7: A read presents the stored byte on `reg_rdata` one cycle later. `reg_rdata` then holds until the next read and never shows the live count.
- R8: While all four digits are zero, no tick produces an expiry.
- R9: A write changes only the addressed register. The two registers may be written in either order.
- R10: Cycles without `tick_100hz` and without an access leave the countdown unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_100hz | input | 1 | One-cycle count enable, nominally 100 Hz |
| reg_sel | input | 1 | Register access strobe (read or write) |
| reg_wr | input | 1 | 1 = write, 0 = read, qualified by `reg_sel` |
| reg_addr | input | 1 | 0 = hundredths/tenths byte, 1 = seconds byte |
| reg_wdata | input | 8 | Write data, two BCD digits |
| reg_rdata | output | 8 | Registered read data |
| expire_pulse | output | 1 | One-cycle strobe at each expiry |
| wd_flag | output | 1 | Sticky watchdog flag |
| wd_irq_n | output | 1 | Active-low watchdog interrupt |

## Verification
The bench checks three borrow paths: a single digit, a ripple from the seconds digit down to zero hundredths (period 01.00), and the 99.99 maximum. An off-by-one borrow would shift expiry by 9 or 90 ticks. It places a kick in the same cycle as the tick that would have expired, so a design that lets the tick win raises a spurious flag. It lets the timer run past several reloads, so a flag that drops on reload, or a missing repeat strobe, is caught. It also checks that reads restart the count, and that an all-zero period stays silent instead of wrapping to 9999.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;

  // one BCD digit minus one, wrapping 0 to 9
  function automatic digit_t digit_dec(digit_t d);
    return (d == '0) ? digit_t'(9) : d - digit_t'(1);
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs #(
  parameter int BYTE_W = 8,
  parameter int NREG   = 2,
  localparam int AW    = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sel,
  input  logic                   wr,
  input  logic [AW-1:0]          addr,
  input  logic [BYTE_W-1:0]      wdata,
  output logic [BYTE_W-1:0]      rdata_q,
  output logic [NREG*BYTE_W-1:0] period_next
);
  logic [BYTE_W-1:0] regs_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic hit_w;
    assign hit_w = sel && wr && (addr == AW'(i));
    assign period_next[i*BYTE_W +: BYTE_W] = hit_w ? wdata : regs_q[i];
    always_ff @(posedge clk) begin
      if (rst)        regs_q[i] <= '0;
      else if (hit_w) regs_q[i] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              rdata_q <= '0;
    else if (sel && !wr)  rdata_q <= regs_q[addr];
  end

  // R7
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(sel && !wr) |=> $stable(rdata_q));
  // R9
  other_reg_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && wr && addr == AW'(0)) |=> $stable(regs_q[NREG-1]));
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int CW    = DIGITS * DIGIT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          hit,
  output logic          expire_q
);
  logic [CW-1:0]     cnt_q;
  logic [CW-1:0]     dec_val;
  logic [DIGITS-1:0] borrow;

  assign borrow[0] = 1'b1;
  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    digit_t d;
    assign d = cnt_q[i*DIGIT_W +: DIGIT_W];
    assign dec_val[i*DIGIT_W +: DIGIT_W] = borrow[i] ? digit_dec(d) : d;
    if (i < DIGITS - 1) begin : g_bor
      assign borrow[i+1] = borrow[i] & (d == '0);
    end
  end

  assign hit = tick && !load && (cnt_q == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= hit;
      if (load || hit)
        cnt_q <= load_val;
      else if (tick && (cnt_q != '0))
        cnt_q <= dec_val;
    end
  end

  // R10
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(cnt_q));
  // R3
  expire_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(expire_q) |-> ($past(tick) && !$past(load)));
  // R5
  reload_on_expire_chk: assert property (@(posedge clk) disable iff (rst)
    expire_q |-> (cnt_q == $past(load_val)));
  // R8
  zero_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !load) |=> (cnt_q == '0 && !expire_q));
endmodule

// File: rtl/wdog_irq.sv
module wdog_irq (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag_q,
  output logic irq_n_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      flag_q  <= 1'b0;
      irq_n_q <= 1'b1;
    end else if (set) begin
      flag_q  <= 1'b1;
      irq_n_q <= 1'b0;
    end
  end

  // R4
  irq_flag_pair_chk: assert property (@(posedge clk) disable iff (rst)
    irq_n_q == !flag_q);
  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr) |=> flag_q);
  // R6
  access_clears_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!flag_q && irq_n_q));
endmodule

// File: rtl/bcd_wdog.sv
module bcd_wdog
  import wdog_pkg::*;
#(
  parameter int DIGITS = 4,
  parameter int BYTE_W = 8,
  localparam int NREG  = (DIGITS * DIGIT_W) / BYTE_W,
  localparam int AW    = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_100hz,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              expire_pulse,
  output logic              wd_flag,
  output logic              wd_irq_n
);
  logic [NREG*BYTE_W-1:0] period_next;
  logic                   hit;

  wdog_regs #(.BYTE_W(BYTE_W), .NREG(NREG)) u_regs (
    .clk(clk), .rst(rst), .sel(reg_sel), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata_q(reg_rdata), .period_next(period_next)
  );

  wdog_count #(.DIGITS(DIGITS)) u_count (
    .clk(clk), .rst(rst), .tick(tick_100hz), .load(reg_sel),
    .load_val(period_next), .hit(hit), .expire_q(expire_pulse)
  );

  wdog_irq u_irq (
    .clk(clk), .rst(rst), .set(hit), .clr(reg_sel),
    .flag_q(wd_flag), .irq_n_q(wd_irq_n)
  );

  // R3
  pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    expire_pulse |-> wd_flag);
endmodule

// File: tb/bcd_wdog_bench.sv
module bcd_wdog_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_100hz = 1'b0;
  logic       reg_sel = 1'b0;
  logic       reg_wr = 1'b0;
  logic [0:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       expire_pulse, wd_flag, wd_irq_n;

  always #5 clk = ~clk;

  bcd_wdog u_bcd_wdog (
    .clk(clk), .rst(rst), .tick_100hz(tick_100hz), .reg_sel(reg_sel),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .expire_pulse(expire_pulse),
    .wd_flag(wd_flag), .wd_irq_n(wd_irq_n)
  );

  typedef struct {
    logic       flag;
    logic       irq_n;
    logic       pulse;
    logic [7:0] rd;
    string      tag;
  } exp_t;

  exp_t  scb[$];
  int    n_chk = 0;
  int    n_fail = 0;
  string tag = "R1";
  bit    done = 0;

  // reference model, plain decimal integers
  int         m_reg [2];
  int         m_cnt;
  logic       m_flag, m_pulse;
  logic [7:0] m_rd;

  function automatic int period_of();
    return (m_reg[1] >> 4) * 1000 + (m_reg[1] & 15) * 100 +
           (m_reg[0] >> 4) * 10 + (m_reg[0] & 15);
  endfunction

  task automatic push_exp();
    exp_t e;
    e.flag = m_flag; e.irq_n = !m_flag; e.pulse = m_pulse; e.rd = m_rd; e.tag = tag;
    scb.push_back(e);
  endtask

  task automatic cyc(input logic t, input logic s, input logic w,
                     input logic a, input logic [7:0] d);
    @(negedge clk);
    rst = 1'b0; tick_100hz = t; reg_sel = s; reg_wr = w; reg_addr = a; reg_wdata = d;
    m_pulse = 1'b0;
    if (s) begin
      if (w) m_reg[a] = int'(d);
      else   m_rd = 8'(m_reg[a]);
      m_cnt  = period_of();
      m_flag = 1'b0;
    end else if (t && m_cnt != 0) begin
      if (m_cnt == 1) begin
        m_cnt = period_of(); m_flag = 1'b1; m_pulse = 1'b1;
      end else m_cnt--;
    end
    push_exp();
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d); cyc(0, 1, 1, a, d); endtask
  task automatic rd_reg(input logic a); cyc(0, 1, 0, a, 8'h00); endtask
  task automatic ticks(input int n); for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 8'h00); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 8'h00); endtask

  task automatic cmp1(input string what, input logic got, input logic exp, input string t);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual %0b expected %0b", t, what, got, exp);
    end
  endtask

  // monitor: pops one expectation per edge, samples after the edge
  always @(posedge clk) begin
    #2;
    if (scb.size() > 0) begin
      exp_t e;
      e = scb.pop_front();
      cmp1("wd_flag", wd_flag, e.flag, e.tag);
      cmp1("wd_irq_n", wd_irq_n, e.irq_n, e.tag);
      cmp1("expire_pulse", expire_pulse, e.pulse, e.tag);
      n_chk++;
      if (reg_rdata !== e.rd) begin
        n_fail++;
        $display("FAIL %s reg_rdata actual %02h expected %02h", e.tag, reg_rdata, e.rd);
      end
    end
  end

  initial begin
    m_reg[0] = 0; m_reg[1] = 0; m_cnt = 0; m_flag = 0; m_pulse = 0; m_rd = 8'h00;
    // R1: reset state
    tag = "R1";
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); rst = 1'b1; push_exp();
    end
    // R8: default zero period never expires
    tag = "R8"; ticks(20);
    // R2 R3: period 00.05, written low byte first
    tag = "R3"; wr_reg(0, 8'h05); wr_reg(1, 8'h00); ticks(5);
    // R4 R5: left alone, pulses repeat and the flag stays
    tag = "R5"; ticks(16);
    // R6 R7: a read restarts and clears, returns the programmed byte
    tag = "R7"; rd_reg(0); idle(2);
    // R10: idle cycles between ticks do not advance the count
    tag = "R10"; for (int i = 0; i < 12; i++) begin ticks(1); idle(2); end
    // R2 R9: period 01.00, high byte first, borrow ripples
    tag = "R9"; wr_reg(1, 8'h01); wr_reg(0, 8'h00); rd_reg(1); rd_reg(0);
    tag = "R2"; ticks(205);
    // R2: mixed digits, 03.21
    wr_reg(0, 8'h21); wr_reg(1, 8'h03); ticks(330);
    // R6: kicks by read, and a kick in the same cycle as the expiring tick
    tag = "R6"; wr_reg(0, 8'h10); wr_reg(1, 8'h00);
    ticks(7); rd_reg(1); ticks(9); cyc(1, 1, 0, 0, 8'h00); ticks(9); ticks(2);
    // R8: writing zero disables
    tag = "R8"; wr_reg(0, 8'h00); wr_reg(1, 8'h00); ticks(300);
    // R3: maximum period 99.99
    tag = "R3"; wr_reg(0, 8'h99); wr_reg(1, 8'h99); ticks(10001);
    tag = "R7"; rd_reg(1); rd_reg(0); idle(3);
    done = 1;
    @(posedge clk); #4;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL all watchdog actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule